// File: doc/BRIEF.md
# Pattern-Count Saturating Scalar Incrementer

This block adds a step to a scalar value, and the step depends on the vector length. A 5-bit pattern code selects how many byte-wide lanes of a vector are counted as active. The vector length is fixed when the block is elaborated. The choices are:

- all lanes;
- the largest power of two that fits;
- the largest multiple of three or of four that fits;
- one of several fixed counts.

The lane count is multiplied by a small immediate multiplier. The product is added to a signed 64-bit operand, and the sum saturates at the positive limit of the selected operand size.

In 32-bit mode only the low word of the operand takes part. That word is treated as a signed value, clamped to the signed 32-bit range, and then sign-extended across the 64-bit result. In 64-bit mode the whole operand is used, and the sum clamps to the signed 64-bit range. Each accepted request produces a registered result one cycle later, together with a flag that reports whether clamping took place.

The parameter `VEC_BITS` sets the vector length. It must be a multiple of 128 between 128 and 2048, and its default is 640, which gives 80 lanes. The unit has no back-pressure. A request is taken on every clock edge where the valid strobe is high.

Top module: `lane_count_sat_inc`

## Requirements
- R1: While `rstN` is low, and after it rises until the first accepted request, `resValid`, `satFlag` and `resOut` are all zero.
- R2: A request sampled with `inValid` high at one rising edge gives `resValid` high for exactly the following cycle. When `inValid` is low, `resValid` is low and `resOut`/`satFlag` keep their last values.
- R3: The multiplier is `immField` + 1 (1 to 16). The increment is the lane count times that multiplier, and it is never negative.
- R4: Codes 1 to 8 count 1 to 8 lanes, and codes 9 to 13 count 16, 32, 64, 128 and 256 lanes. A fixed count larger than the lane total (`VEC_BITS`/8) yields zero.
- R5: Code 0 counts the largest power of two not above the lane total.
- R6: Code 29 counts the largest multiple of 4, code 30 the largest multiple of 3, and code 31 all lanes, each not above the lane total.
- R7: Codes 14 to 28 count zero lanes, so the result equals the operand, sign-extended from bit 31 in 32-bit mode.
- R8: With `wideMode`=1, a sum above 2^63-1 gives `resOut` = 0x7FFF_FFFF_FFFF_FFFF and `satFlag`=1. A sum at or below that limit is passed through with `satFlag`=0.
- R9: With `wideMode`=0, `opIn[63:32]` is ignored and `opIn[31:0]` is signed. A sum above 2^31-1 gives 0x0000_0000_7FFF_FFFF with `satFlag`=1. Otherwise the 32-bit sum is sign-extended to 64 bits with `satFlag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opIn | input | 64 | Signed operand |
| patternCode | input | 5 | Lane-count pattern selector |
| immField | input | 4 | Multiplier minus one |
| wideMode | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| resOut | output | 64 | Registered result |
| satFlag | output | 1 | Clamping occurred for the current result |
| resValid | output | 1 | Result strobe, one cycle after the request |

## Verification
The bench drives the power-of-two, multiple-of-three and multiple-of-four codes with an 80-lane default. At that length the three codes give 64, 78 and 80 lanes. A decoder that rounds wrongly or swaps the two multiple codes therefore shows a distinct wrong sum. The fixed codes 128 and 256 exceed the lane total and must add nothing; a decoder without the fit check would add them anyway.

Sums that land exactly on each positive limit must not set the flag, while sums one step past must clamp. This exposes an off-by-one compare and any wrap-around caused by a narrow adder. The 32-bit cases place unrelated data in the upper operand word and use negative low words. A unit that saturates at 64 bits, or zero-extends instead of sign-extending, returns visibly wrong upper halves.

// File: rtl/lcsi_pkg.sv
package lcsi_pkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic capture;  // load result registers this edge
    logic wide;     // 64-bit operation when set
  } ctrlStrobe_t;

  localparam int SUM_W = 66;  // operand 64 + headroom so no sum can wrap
  localparam int MULT_W = 5;  // immediate multiplier 1..16
endpackage

// File: rtl/lcsi_lane_decode.sv
module lcsi_lane_decode #(
  parameter int LANES = 80,
  parameter int CNT_W = 7
) (
  input  logic [4:0]       patternCode,
  output logic [CNT_W-1:0] laneCount
);
  // Largest power of two not above n
  function automatic int pow2Floor(int n);
    int p = 1;
    for (int i = 0; i < 12; i++) begin
      if ((1 << i) <= n) p = 1 << i;
    end
    return p;
  endfunction

  localparam int CNT_POW2 = pow2Floor(LANES);
  localparam int CNT_MUL4 = LANES - (LANES % 4);
  localparam int CNT_MUL3 = LANES - (LANES % 3);
  localparam int CNT_ALL  = LANES;

  int fixedCnt;
  int chosen;

  always_comb begin
    fixedCnt = 0;
    if (patternCode >= 5'd1 && patternCode <= 5'd8)
      fixedCnt = int'(patternCode);
    else if (patternCode >= 5'd9 && patternCode <= 5'd13)
      fixedCnt = 16 << (int'(patternCode) - 9);

    case (patternCode)
      5'd0:    chosen = CNT_POW2;
      5'd29:   chosen = CNT_MUL4;
      5'd30:   chosen = CNT_MUL3;
      5'd31:   chosen = CNT_ALL;
      default: chosen = (fixedCnt <= LANES) ? fixedCnt : 0;
    endcase
    laneCount = CNT_W'(chosen);
  end

  always_comb begin
    if (!$isunknown(patternCode)) begin
      assert_count_bound_R4: assert (int'(laneCount) <= LANES)
        else $error("lane count above lane total");
      if (patternCode >= 5'd14 && patternCode <= 5'd28) begin
        assert_unalloc_zero_R7: assert (laneCount == '0)
          else $error("unallocated pattern gave nonzero count");
      end
    end
  end
endmodule

// File: rtl/lcsi_ctrl.sv
module lcsi_ctrl
  import lcsi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        wideMode,
  output ctrlStrobe_t strobe,
  output logic        resValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.wide    = wideMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);
endmodule

// File: rtl/lcsi_datapath.sv
module lcsi_datapath
  import lcsi_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [63:0]      opIn,
  input  logic [CNT_W-1:0] laneCount,
  input  logic [3:0]       immField,
  output logic [63:0]      resOut,
  output logic             satFlag
);
  localparam int PROD_W = CNT_W + MULT_W;
  localparam logic [SUM_W-1:0] LIM64 = SUM_W'(64'h7FFF_FFFF_FFFF_FFFF);
  localparam logic [SUM_W-1:0] LIM32 = SUM_W'(32'h7FFF_FFFF);

  logic [MULT_W-1:0] multVal;
  logic [PROD_W-1:0] stepVal;
  logic [SUM_W-1:0]  opExt;
  logic [SUM_W-1:0]  sumVal;
  logic [SUM_W-1:0]  limitVal;
  logic              overLim;
  logic [SUM_W-1:0]  clampVal;
  logic [63:0]       nextRes;
  logic              wideQ;

  always_comb begin
    multVal  = MULT_W'(immField) + MULT_W'(1);
    stepVal  = PROD_W'(laneCount) * PROD_W'(multVal);
    opExt    = strobe.wide ? SUM_W'($signed(opIn)) : SUM_W'($signed(opIn[31:0]));
    sumVal   = opExt + SUM_W'(stepVal);
    limitVal = strobe.wide ? LIM64 : LIM32;
    overLim  = $signed(sumVal) > $signed(limitVal);
    clampVal = overLim ? limitVal : sumVal;
    nextRes  = strobe.wide ? clampVal[63:0] : {{32{clampVal[31]}}, clampVal[31:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut  <= '0;
      satFlag <= 1'b0;
      wideQ   <= 1'b1;
    end else if (strobe.capture) begin
      resOut  <= nextRes;
      satFlag <= overLim;
      wideQ   <= strobe.wide;
    end
  end

  assert_sext_narrow_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wideQ |-> resOut[63:32] == {32{resOut[31]}});
  assert_sat_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && wideQ) |-> resOut == 64'h7FFF_FFFF_FFFF_FFFF);
  assert_sat_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !wideQ) |-> resOut == 64'h0000_0000_7FFF_FFFF);
  assert_no_decrease_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.wide) |=> $signed(resOut) >= $signed($past(opIn)));
endmodule

// File: rtl/lane_count_sat_inc.sv
module lane_count_sat_inc
  import lcsi_pkg::*;
#(
  parameter int VEC_BITS = 640
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] opIn,
  input  logic [4:0]  patternCode,
  input  logic [3:0]  immField,
  input  logic        wideMode,
  output logic [63:0] resOut,
  output logic        satFlag,
  output logic        resValid
);
  localparam int LANES = VEC_BITS / 8;
  localparam int CNT_W = $clog2(LANES + 1);

  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] laneCount;

  lcsi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wideMode(wideMode),
    .strobe(strobe), .resValid(resValid)
  );

  lcsi_lane_decode #(.LANES(LANES), .CNT_W(CNT_W)) u_decode (
    .patternCode(patternCode), .laneCount(laneCount)
  );

  lcsi_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIn(opIn),
    .laneCount(laneCount), .immField(immField),
    .resOut(resOut), .satFlag(satFlag)
  );
endmodule

// File: tb/lane_count_sat_inc_bench.sv
module lane_count_sat_inc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VEC = 640;
  localparam int NLANES = VEC / 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opIn = '0;
  logic [4:0]  patternCode = '0;
  logic [3:0]  immField = '0;
  logic        wideMode = 1'b1;
  logic [63:0] resOut;
  logic        satFlag;
  logic        resValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_count_sat_inc #(.VEC_BITS(VEC)) u_lane_count_sat_inc (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opIn(opIn),
    .patternCode(patternCode), .immField(immField), .wideMode(wideMode),
    .resOut(resOut), .satFlag(satFlag), .resValid(resValid)
  );

  task automatic checkEq(string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Lane count from the requirements
  function automatic int expCount(int code);
    int p = 1;
    int f = 0;
    if (code == 0) begin
      while (p * 2 <= NLANES) p = p * 2;
      return p;
    end
    if (code == 29) return NLANES - NLANES % 4;
    if (code == 30) return NLANES - NLANES % 3;
    if (code == 31) return NLANES;
    if (code >= 1 && code <= 8) f = code;
    else if (code >= 9 && code <= 13) f = 16 << (code - 9);
    return (f <= NLANES) ? f : 0;
  endfunction

  task automatic runOp(string req, logic [63:0] op, int code, int imm, bit wide);
    logic signed [65:0] s;
    logic signed [65:0] lim;
    logic [63:0] expRes;
    logic expSat;
    s = wide ? 66'($signed(op)) : 66'($signed(op[31:0]));
    s = s + 66'(expCount(code) * (imm + 1));
    lim = wide ? 66'(64'h7FFF_FFFF_FFFF_FFFF) : 66'(32'h7FFF_FFFF);
    expSat = s > lim;
    if (expSat) s = lim;
    expRes = wide ? s[63:0] : {{32{s[31]}}, s[31:0]};
    @(negedge clk);
    opIn = op; patternCode = 5'(code); immField = 4'(imm); wideMode = wide; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkEq({req, " valid"}, 64'(resValid), 64'd1);
    checkEq({req, " result"}, resOut, expRes);
    checkEq({req, " flag"}, 64'(satFlag), 64'(expSat));
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R1 valid in reset", 64'(resValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 valid", 64'(resValid), 64'd0);
    checkEq("R1 result", resOut, 64'd0);
    checkEq("R1 flag", 64'(satFlag), 64'd0);
  endtask

  task automatic tFixed();
    for (int c = 1; c <= 13; c++) runOp("R4 fixed", 64'd100, c, 0, 1'b1);
    runOp("R4 over-length 128", 64'd7, 12, 3, 1'b1);
    runOp("R4 over-length 256", 64'd7, 13, 0, 1'b1);
  endtask

  task automatic tSpecial();
    runOp("R5 pow2", 64'd0, 0, 2, 1'b1);
    runOp("R6 mul4", 64'd0, 29, 0, 1'b1);
    runOp("R6 mul3", 64'd0, 30, 0, 1'b1);
    runOp("R6 all", 64'd0, 31, 0, 1'b1);
  endtask

  task automatic tUnalloc();
    for (int c = 14; c <= 28; c++) runOp("R7 unalloc", -64'sd5, c, 15, 1'b1);
    runOp("R7 unalloc narrow", 64'hAAAA_5555_8000_0000, 20, 7, 1'b0);
  endtask

  task automatic tMult();
    runOp("R3 imm15 negative op", -64'sd1000, 31, 15, 1'b1);
    runOp("R3 imm7 mul3", 64'd3, 30, 7, 1'b1);
  endtask

  task automatic tSat64();
    runOp("R8 clamp", 64'h7FFF_FFFF_FFFF_FF00, 31, 15, 1'b1);
    runOp("R8 exact limit", 64'h7FFF_FFFF_FFFF_FFFF - 64'd80, 31, 0, 1'b1);
    runOp("R8 one past", 64'h7FFF_FFFF_FFFF_FFFF - 64'd79, 31, 0, 1'b1);
  endtask

  task automatic tSat32();
    runOp("R9 clamp", 64'hDEAD_BEEF_7FFF_FF00, 31, 15, 1'b0);
    runOp("R9 negative", 64'h1234_5678_FFFF_FF00, 31, 0, 1'b0);
    runOp("R9 exact limit", 64'hFFFF_FFFF_7FFF_FFAF, 31, 0, 1'b0);
    runOp("R9 one past", 64'h0000_0001_7FFF_FFB0, 31, 0, 1'b0);
  endtask

  task automatic tHold();
    logic [63:0] held;
    runOp("R2 setup", 64'h7FFF_FFFF_FFFF_FFF0, 31, 1, 1'b1);
    held = resOut;
    @(negedge clk);
    opIn = 64'd1; patternCode = 5'd1; wideMode = 1'b0;
    @(negedge clk);
    checkEq("R2 valid low", 64'(resValid), 64'd0);
    checkEq("R2 result held", resOut, held);
    checkEq("R2 flag held", 64'(satFlag), 64'd1);
  endtask

  initial begin
    tReset();
    tFixed();
    tSpecial();
    tUnalloc();
    tMult();
    tSat64();
    tSat32();
    tHold();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule